// File: doc/BRIEF.md
# Multicycle Sixteen-Register Processor Core

This block is a small processor built from a finite-state controller and a datapath. The datapath holds a 16-bit program counter, a 16-bit instruction register, a sixteen-entry file of 16-bit registers and one adder/subtractor with a zero flag. Instructions and data share one 16-bit-wide memory, reached through a single port. The memory sits outside the block and answers a read on the clock edge after the request.

Every instruction takes several cycles. The controller leaves `RESET` for `FETCH`, which drives the program counter onto the address and asserts read. `FETCH_WAIT` captures the returned word into the instruction register and advances the program counter. `DECODE` branches on the 4-bit opcode to one execute state: `LD_DIR` then `LD_WAIT`, `ST_DIR`, `ST_IND`, `LD_IMM`, `ADD`, `SUB`, `JZ` or `NOP`. Every execute state returns to `FETCH`. Debug outputs expose the program counter, the instruction register and the state code, so a bench can follow execution.

Top module: `proc_core`

## Requirements
- R1: While reset is held, the state code is 0 (`RESET`), the program counter is 0 and no memory write is issued. The first clock after release enters `FETCH` (state code 1).
- R2: In `FETCH` the block asserts read with the program counter on the address. One cycle later, in `FETCH_WAIT` (state code 2), it loads the returned word into the instruction register and increments the program counter by 1. It then enters `DECODE` (state code 3).
- R3: Opcode 0000 (instruction bits 15:12) loads register `rn` (bits 11:8) from memory at the 8-bit direct address (bits 7:0), zero-extended.
- R4: Opcode 0001 writes register `rn` to memory at the zero-extended direct address (bits 7:0).
- R5: Opcode 0010 writes register `rm` (bits 7:4) to the memory address held in register `rn`. This holds also when `rn` equals `rm`.
- R6: Opcode 0011 loads register `rn` with the 8-bit immediate (bits 7:0), zero-extended to 16 bits.
- R7: Opcode 0100 sets `rn` to `rn + rm` modulo 2^16. This holds also when `rn` equals `rm`.
- R8: Opcode 0101 sets `rn` to `rn - rm` modulo 2^16.
- R9: Opcode 0110 loads the program counter with the zero-extended target field (bits 7:0) when register `rn` is zero. Otherwise the program counter keeps its incremented value.
- R10: Opcodes 0111 to 1111 change no register and write no memory. Execution continues with the next word.
- R11: The loop program that adds 10 down to 1 leaves 55 in register 0.
- R12: Memory read and memory write are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address to the shared memory |
| mem_wdata | output | 16 | Data written to memory |
| mem_rdata | input | 16 | Data returned by memory, one cycle after a read |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| dbg_pc | output | 16 | Current program counter |
| dbg_ir | output | 16 | Current instruction register |
| dbg_state | output | 4 | Current controller state code |

## Verification
The indirect store uses both register read ports in one cycle. One port supplies the address and the other the data. An add reads and writes its destination register in the same cycle. The bench provokes both coincidences with `rn` equal to `rm`: a register stores itself at its own address, and a register is doubled. It judges the results only from the memory words they leave behind. A taken jump reloads the program counter in the same instruction slot whose fetch already incremented it. Skipped words whose stores would overwrite preset memory show whether that update wins.

// File: rtl/proc_pkg.sv
package proc_pkg;
    localparam int XLEN   = 16;
    localparam int NREG   = 16;
    localparam int RIDX   = $clog2(NREG);
    localparam int OPW    = 4;
    localparam int FLDW   = 8;

    typedef enum logic [3:0] {
        ST_RESET      = 4'd0,
        ST_FETCH      = 4'd1,
        ST_FETCH_WAIT = 4'd2,
        ST_DECODE     = 4'd3,
        ST_LD_DIR     = 4'd4,
        ST_LD_WAIT    = 4'd5,
        ST_ST_DIR     = 4'd6,
        ST_ST_IND     = 4'd7,
        ST_LD_IMM     = 4'd8,
        ST_ADD        = 4'd9,
        ST_SUB        = 4'd10,
        ST_JZ         = 4'd11,
        ST_NOP        = 4'd12
    } state_t;

    localparam logic [OPW-1:0] OP_LOAD_DIR  = 4'b0000;
    localparam logic [OPW-1:0] OP_STORE_DIR = 4'b0001;
    localparam logic [OPW-1:0] OP_STORE_IND = 4'b0010;
    localparam logic [OPW-1:0] OP_LOAD_IMM  = 4'b0011;
    localparam logic [OPW-1:0] OP_ADD       = 4'b0100;
    localparam logic [OPW-1:0] OP_SUB       = 4'b0101;
    localparam logic [OPW-1:0] OP_JZ        = 4'b0110;

    localparam logic [1:0] WSEL_ALU = 2'b00;
    localparam logic [1:0] WSEL_MEM = 2'b01;
    localparam logic [1:0] WSEL_IMM = 2'b10;

    localparam logic [1:0] ASEL_PC  = 2'b00;
    localparam logic [1:0] ASEL_DIR = 2'b01;
    localparam logic [1:0] ASEL_REG = 2'b10;

    localparam logic [1:0] ALU_ADD  = 2'b00;
    localparam logic [1:0] ALU_SUB  = 2'b01;

    typedef struct packed {
        logic [RIDX-1:0] rf_wa;
        logic            rf_we;
        logic [1:0]      rf_wsel;
        logic [RIDX-1:0] r1a;
        logic            r1e;
        logic [RIDX-1:0] r2a;
        logic            r2e;
        logic [1:0]      alu_op;
        logic [1:0]      asel;
        logic            mem_re;
        logic            mem_we;
        logic            ir_ld;
        logic            pc_inc;
        logic            pc_clr;
    } ctrl_t;
endpackage

// File: rtl/proc_regfile.sv
module proc_regfile #(
    parameter int DW    = 16,
    parameter int NR    = 16,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           wa,
    input  logic                    we,
    input  logic [DW-1:0]           wd,
    input  logic [NRD-1:0][AW-1:0]  ra,
    input  logic [NRD-1:0]          re,
    output logic [NRD-1:0][DW-1:0]  rd
);
    logic [DW-1:0] regs [NR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    // each read port returns zero while its enable is low
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd[p] = re[p] ? regs[ra[p]] : '0;
    end
endmodule

// File: rtl/proc_alu.sv
module proc_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    op,
    output logic [DW-1:0] y,
    output logic          zero
);
    import proc_pkg::*;

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/proc_ctrl.sv
module proc_ctrl
    import proc_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ir,
    input  logic          alu_zero,
    output ctrl_t         c,
    output logic          pc_ld,
    output state_t        state
);
    state_t nxt;
    logic [OPW-1:0]  op;
    logic [RIDX-1:0] rn, rm;

    assign op = ir[IW-1 -: OPW];
    assign rn = ir[IW-OPW-1 -: RIDX];
    assign rm = ir[IW-OPW-RIDX-1 -: RIDX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_RESET:      nxt = ST_FETCH;
            ST_FETCH:      nxt = ST_FETCH_WAIT;
            ST_FETCH_WAIT: nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (op)
                    OP_LOAD_DIR:  nxt = ST_LD_DIR;
                    OP_STORE_DIR: nxt = ST_ST_DIR;
                    OP_STORE_IND: nxt = ST_ST_IND;
                    OP_LOAD_IMM:  nxt = ST_LD_IMM;
                    OP_ADD:       nxt = ST_ADD;
                    OP_SUB:       nxt = ST_SUB;
                    OP_JZ:        nxt = ST_JZ;
                    default:      nxt = ST_NOP;
                endcase
            end
            ST_LD_DIR:     nxt = ST_LD_WAIT;
            default:       nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        c = '0;
        unique case (state)
            ST_RESET: c.pc_clr = 1'b1;
            ST_FETCH: begin
                c.asel   = ASEL_PC;
                c.mem_re = 1'b1;
            end
            ST_FETCH_WAIT: begin
                c.ir_ld  = 1'b1;
                c.pc_inc = 1'b1;
            end
            ST_LD_DIR: begin
                c.asel   = ASEL_DIR;
                c.mem_re = 1'b1;
            end
            ST_LD_WAIT: begin
                c.rf_wa   = rn;
                c.rf_we   = 1'b1;
                c.rf_wsel = WSEL_MEM;
            end
            ST_ST_DIR: begin
                c.asel   = ASEL_DIR;
                c.r2a    = rn;
                c.r2e    = 1'b1;
                c.mem_we = 1'b1;
            end
            ST_ST_IND: begin
                c.r1a    = rn;
                c.r1e    = 1'b1;
                c.asel   = ASEL_REG;
                c.r2a    = rm;
                c.r2e    = 1'b1;
                c.mem_we = 1'b1;
            end
            ST_LD_IMM: begin
                c.rf_wa   = rn;
                c.rf_we   = 1'b1;
                c.rf_wsel = WSEL_IMM;
            end
            ST_ADD, ST_SUB: begin
                c.r1a     = rn;
                c.r1e     = 1'b1;
                c.r2a     = rm;
                c.r2e     = 1'b1;
                c.alu_op  = (state == ST_SUB) ? ALU_SUB : ALU_ADD;
                c.rf_wa   = rn;
                c.rf_we   = 1'b1;
                c.rf_wsel = WSEL_ALU;
            end
            ST_JZ: begin
                c.r1a    = rn;
                c.r1e    = 1'b1;
                c.alu_op = ALU_ADD;
            end
            default: c = '0;
        endcase
    end

    // second operand is disabled in JZ, so the flag reflects rn alone
    assign pc_ld = (state == ST_JZ) && alu_zero;

    // R10
    nop_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOP) |=> (state == ST_FETCH));

    // R2
    decode_follows_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_WAIT) |=> (state == ST_DECODE));

    // R12
    no_dual_regwrite_memwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c.rf_we, c.mem_we, c.ir_ld}));
endmodule

// File: rtl/proc_core.sv
module proc_core
    import proc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        mem_re,
    output logic        mem_we,
    output logic [15:0] dbg_pc,
    output logic [15:0] dbg_ir,
    output logic [3:0]  dbg_state
);
    ctrl_t          c;
    state_t         state;
    logic           pc_ld;
    logic           alu_zero;
    logic [XLEN-1:0] pc, ir;
    logic [XLEN-1:0] fld_ext, alu_y, rf_wd;
    logic [1:0][XLEN-1:0] rf_rd;

    assign fld_ext = {{(XLEN-FLDW){1'b0}}, ir[FLDW-1:0]};

    proc_ctrl #(.IW(XLEN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir       (ir),
        .alu_zero (alu_zero),
        .c        (c),
        .pc_ld    (pc_ld),
        .state    (state)
    );

    proc_regfile #(.DW(XLEN), .NR(NREG), .NRD(2)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .wa    (c.rf_wa),
        .we    (c.rf_we),
        .wd    (rf_wd),
        .ra    ({c.r2a, c.r1a}),
        .re    ({c.r2e, c.r1e}),
        .rd    (rf_rd)
    );

    proc_alu #(.DW(XLEN)) u_alu (
        .a    (rf_rd[0]),
        .b    (rf_rd[1]),
        .op   (c.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        unique case (c.rf_wsel)
            WSEL_MEM: rf_wd = mem_rdata;
            WSEL_IMM: rf_wd = fld_ext;
            default:  rf_wd = alu_y;
        endcase
    end

    always_comb begin
        unique case (c.asel)
            ASEL_DIR: mem_addr = fld_ext;
            ASEL_REG: mem_addr = rf_rd[0];
            default:  mem_addr = pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (c.pc_clr)      pc <= '0;
            else if (pc_ld)    pc <= fld_ext;
            else if (c.pc_inc) pc <= pc + 1'b1;
            if (c.ir_ld)       ir <= mem_rdata;
        end
    end

    assign mem_wdata = rf_rd[1];
    assign mem_re    = c.mem_re;
    assign mem_we    = c.mem_we;
    assign dbg_pc    = pc;
    assign dbg_ir    = ir;
    assign dbg_state = state;

    // R12
    excl_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R1
    reset_pc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |=> (pc == '0) && (state == ST_FETCH));

    // R2
    fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_WAIT) |=> (pc == $past(pc) + 16'd1) && (ir == $past(mem_rdata)));

    // R9
    jz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JZ && !alu_zero) |=> (pc == $past(pc)));

    // R9
    jz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JZ && alu_zero) |=> (pc == {8'h00, $past(ir[7:0])}));
endmodule

// File: tb/tb_proc_core.sv
`timescale 1ns/1ps
module tb_proc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_re, mem_we;
    logic [15:0] dbg_pc, dbg_ir;
    logic [3:0]  dbg_state;

    logic [15:0] mem [256];
    int total = 0;
    int bad = 0;
    int both_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    proc_core dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_re(mem_re), .mem_we(mem_we),
        .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_state(dbg_state)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(negedge clk)
        if (rst_n && mem_re && mem_we) both_cnt++;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input int n);
        hold_reset();
        rst_n = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = 16'h3A5C;
        hold_reset();
        chk("R1 state in reset", {12'h0, dbg_state}, 16'd0);
        chk("R1 pc in reset", dbg_pc, 16'd0);
        chk("R1 no write in reset", {15'h0, mem_we}, 16'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 enters fetch", {12'h0, dbg_state}, 16'd1);
        chk("R2 fetch reads", {15'h0, mem_re}, 16'd1);
        chk("R2 fetch addr", mem_addr, 16'd0);
        @(posedge clk); #1;
        chk("R2 fetch wait", {12'h0, dbg_state}, 16'd2);
        @(posedge clk); #1;
        chk("R2 ir captured", dbg_ir, 16'h3A5C);
        chk("R2 pc incremented", dbg_pc, 16'd1);
        chk("R2 decode", {12'h0, dbg_state}, 16'd3);
    endtask

    task automatic t_load_store();
        clear_mem();
        mem[8'h40] = 16'hBEEF;
        mem[0] = 16'h0540;
        mem[1] = 16'h1541;
        mem[2] = 16'h36FF;
        mem[3] = 16'h1642;
        mem[4] = 16'h6F04;
        run(200);
        chk("R3 R4 load then store", mem[8'h41], 16'hBEEF);
        chk("R6 immediate zero extended", mem[8'h42], 16'h00FF);
    endtask

    task automatic t_indirect();
        clear_mem();
        mem[8'h60] = 16'h1111;
        mem[0] = 16'h3150;
        mem[1] = 16'h3277;
        mem[2] = 16'h2120;
        mem[3] = 16'h3360;
        mem[4] = 16'h2330;
        mem[5] = 16'h6F05;
        run(200);
        chk("R5 indirect store", mem[8'h50], 16'h0077);
        chk("R5 indirect store rn==rm", mem[8'h60], 16'h0060);
    endtask

    task automatic t_arith();
        clear_mem();
        mem[8'h72] = 16'h1234;
        mem[0] = 16'h31FF;
        mem[1] = 16'h4110;
        mem[2] = 16'h1170;
        mem[3] = 16'h3201;
        mem[4] = 16'h3300;
        mem[5] = 16'h5320;
        mem[6] = 16'h1371;
        mem[7] = 16'h4320;
        mem[8] = 16'h1372;
        mem[9] = 16'h6F09;
        run(300);
        chk("R7 add rn==rm", mem[8'h70], 16'h01FE);
        chk("R8 sub wraps", mem[8'h71], 16'hFFFF);
        chk("R7 add wraps", mem[8'h72], 16'h0000);
    endtask

    task automatic t_jz();
        clear_mem();
        mem[8'h74] = 16'h5555;
        mem[0] = 16'h3101;
        mem[1] = 16'h6106;
        mem[2] = 16'h34AA;
        mem[3] = 16'h1473;
        mem[4] = 16'h3200;
        mem[5] = 16'h6208;
        mem[6] = 16'h34BB;
        mem[7] = 16'h1474;
        mem[8] = 16'h1475;
        mem[9] = 16'h6F09;
        run(300);
        chk("R9 not taken falls through", mem[8'h73], 16'h00AA);
        chk("R9 taken skips store", mem[8'h74], 16'h5555);
        chk("R9 taken target reached", mem[8'h75], 16'h00AA);
    endtask

    task automatic t_undef();
        clear_mem();
        mem[8'h23] = 16'hCAFE;
        mem[8'hFF] = 16'h7777;
        mem[0] = 16'h3105;
        mem[1] = 16'h7123;
        mem[2] = 16'hF1FF;
        mem[3] = 16'h9100;
        mem[4] = 16'h1180;
        mem[5] = 16'h6F05;
        run(200);
        chk("R10 register untouched", mem[8'h80], 16'h0005);
        chk("R10 no write 0x23", mem[8'h23], 16'hCAFE);
        chk("R10 no write 0xFF", mem[8'hFF], 16'h7777);
    endtask

    task automatic t_sum();
        clear_mem();
        mem[0] = 16'h3000;
        mem[1] = 16'h310A;
        mem[2] = 16'h3201;
        mem[3] = 16'h3300;
        mem[4] = 16'h6108;
        mem[5] = 16'h4010;
        mem[6] = 16'h5120;
        mem[7] = 16'h6304;
        mem[8] = 16'h1090;
        mem[9] = 16'h6F09;
        run(1000);
        chk("R11 sum of 10 down to 1", mem[8'h90], 16'd55);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_load_store();
        t_indirect();
        t_arith();
        t_jz();
        t_undef();
        t_sum();
        chk("R12 read and write never together", both_cnt[15:0], 16'd0);
        summary();
    end
endmodule